// File: doc/BRIEF.md
# Gated Frequency Counter with Interrupts

This block measures the rate of a digital input signal. It counts the input's rising edges inside a timed window. A free-running clock is divided down to a timebase tick, and a window generator holds the gate open for a number of ticks. That number comes from a 3-bit resolution code. A second tick source, supplied from outside, can stand in for the divided clock. Qualified edges advance an 8-bit prescaler. Each time the prescaler wraps, it advances a wider event counter. The measured edge count is therefore the concatenation {event, prescaler}.

A CPU starts a measurement with one control write, then waits for the completion interrupt. It reads the two counters back through separate read strobes, and acknowledges completion by pulling the acknowledge line low. An event-counter wrap raises a sticky overflow interrupt that survives later measurements until software clears it.

The input is brought into the clock domain by a two-stage synchronizer. Edges are detected synchronously, so no counter is clocked by the input itself.

Top module: `gated_freq_counter`

## Requirements
- R1: While and after reset, gate_o, irq_done_o and irq_ovf_o are 0 and rd_data_o is 0.
- R2: A write with wr_data_i[0]=1 starts a measurement. It clears both counters and raises gate_o on the next cycle. The write also latches the resolution code from wr_data_i[3:1] and the tick-source select from wr_data_i[4]. A write with wr_data_i[5]=1 clears the overflow flag.
- R3: With the internal tick, one tick occurs every TB_DIV clocks, counted from the start. The gate stays open for 100·BASE_TICKS ticks for code 0, 10·BASE_TICKS ticks for code 1 and BASE_TICKS ticks for codes 2 to 7. gate_o is therefore high for exactly ticks·TB_DIV cycles.
- R4: When wr_data_i[4]=1 at start, the window counts alt_tick_i pulses instead. With alt_tick_i held high, gate_o stays high for exactly the tick count in cycles.
- R5: Each rising edge of sig_i that falls inside the window increments the prescaler. This holds when sig_i stays high and low for at least 2 cycles each. A prescaler wrap from 255 to 0 increments the event counter, so {event, prescaler} equals the edge count modulo 2^(EVT_W+8).
- R6: Edges on sig_i while the gate is closed leave both counters unchanged.
- R7: A cycle with rd_pre_i=1 loads the prescaler, zero-extended, into rd_data_o on the next cycle. A cycle with only rd_evt_i=1 loads the event counter instead. rd_pre_i wins when both are high. With neither strobe, rd_data_o holds its value.
- R8: irq_done_o is set in the cycle the gate closes, provided irq_ack_i is high. It is cleared on the cycle after irq_ack_i is low, and it is never set by a close that happens while irq_ack_i is low.
- R9: An event-counter wrap sets irq_ovf_o. The flag persists across new measurements until a clear write arrives, and a wrap in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Asynchronous signal to be measured |
| alt_tick_i | input | 1 | Alternate timebase tick, one-cycle pulses |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 6 | Control word: start, resolution code, tick select, overflow clear |
| rd_pre_i | input | 1 | Read strobe for the prescaler |
| rd_evt_i | input | 1 | Read strobe for the event counter |
| irq_ack_i | input | 1 | Completion acknowledge, active low clears |
| rd_data_o | output | RD_W | Registered read data |
| gate_o | output | 1 | Measurement window open |
| irq_done_o | output | 1 | Measurement-complete interrupt |
| irq_ovf_o | output | 1 | Sticky event-counter overflow interrupt |

## Verification
A short burst of 20 edges checks exact counting in the prescaler alone. A burst of 300 edges crosses one prescaler wrap and separates a correct carry into the event counter from a missing or doubled one. A burst of 4100 edges with a narrow event counter forces a wrap of the full count, which exposes the overflow flag and its stickiness. Edges sent after the window closes, windows with no edges, and windows timed by a constant alternate tick tell gating faults apart from timebase and table faults.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  // control word bit positions
  localparam int CTL_START   = 0;
  localparam int CTL_RES_LSB = 1;
  localparam int CTL_ALT     = 4;
  localparam int CTL_OVF_CLR = 5;
  localparam int CTL_W       = 6;

  typedef enum logic [1:0] {WIN_SHORT, WIN_MID, WIN_LONG} win_sel_e;

  function automatic win_sel_e decode_res(input logic [2:0] code);
    case (code)
      3'd0:    return WIN_LONG;
      3'd1:    return WIN_MID;
      default: return WIN_SHORT;
    endcase
  endfunction
endpackage

// File: rtl/gfc_timebase.sv
module gfc_timebase #(
  parameter int TB_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic restart_i,
  input  logic run_i,
  input  logic alt_sel_i,
  input  logic alt_tick_i,
  output logic tick_o
);
  localparam int DIV_W = (TB_DIV > 1) ? $clog2(TB_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TB_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) div_q <= '0;
    else if (run_i)         div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
  end

  assign tick_o = run_i & (alt_sel_i ? alt_tick_i : (div_q == DIV_LAST));
endmodule

// File: rtl/gfc_gate.sv
module gfc_gate
  import gfc_pkg::*;
#(
  parameter int BASE_TICKS = 4000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       start_i,
  input  logic [2:0] code_i,
  input  logic       tick_i,
  output logic       gate_o,
  output logic       fin_o
);
  localparam int LONG_TICKS = BASE_TICKS * 100;
  localparam int MID_TICKS  = BASE_TICKS * 10;
  localparam int CW         = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] tcnt_q, lim_q;
  logic          gate_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gate_q <= 1'b0;
      tcnt_q <= '0;
      lim_q  <= '0;
    end else if (start_i) begin
      gate_q <= 1'b1;
      tcnt_q <= '0;
      case (decode_res(code_i))
        WIN_LONG: lim_q <= CW'(LONG_TICKS - 1);
        WIN_MID:  lim_q <= CW'(MID_TICKS - 1);
        default:  lim_q <= CW'(BASE_TICKS - 1);
      endcase
    end else if (gate_q && tick_i) begin
      if (tcnt_q == lim_q) gate_q <= 1'b0;
      tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign gate_o = gate_q;
  assign fin_o  = gate_q & tick_i & (tcnt_q == lim_q);
endmodule

// File: rtl/gfc_edge_count.sv
module gfc_edge_count #(
  parameter int PRE_W = 8,
  parameter int EVT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clear_i,
  input  logic             gate_i,
  input  logic             sig_i,
  output logic [PRE_W-1:0] pre_o,
  output logic [EVT_W-1:0] evt_o,
  output logic             wrap_o
);
  logic             s_meta_q, s_sync_q, s_prev_q;
  logic [PRE_W-1:0] pre_q;
  logic [EVT_W-1:0] evt_q;
  logic             inc;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s_meta_q <= 1'b0;
      s_sync_q <= 1'b0;
      s_prev_q <= 1'b0;
    end else begin
      s_meta_q <= sig_i;
      s_sync_q <= s_meta_q;
      s_prev_q <= s_sync_q;
    end
  end

  assign inc = gate_i & s_sync_q & ~s_prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      pre_q <= '0;
      evt_q <= '0;
    end else if (inc) begin
      pre_q <= pre_q + 1'b1;
      if (&pre_q) evt_q <= evt_q + 1'b1;
    end
  end

  assign pre_o  = pre_q;
  assign evt_o  = evt_q;
  assign wrap_o = inc & (&pre_q) & (&evt_q) & ~clear_i;
endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import gfc_pkg::*;
#(
  parameter int TB_DIV     = 5,
  parameter int BASE_TICKS = 4000,
  parameter int PRE_W      = 8,
  parameter int EVT_W      = 16,
  localparam int RD_W      = (EVT_W > PRE_W) ? EVT_W : PRE_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sig_i,
  input  logic             alt_tick_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  input  logic             rd_pre_i,
  input  logic             rd_evt_i,
  input  logic             irq_ack_i,
  output logic [RD_W-1:0]  rd_data_o,
  output logic             gate_o,
  output logic             irq_done_o,
  output logic             irq_ovf_o
);
  logic             start, ovf_clr, alt_q, tick, gate, fin, wrap;
  logic [PRE_W-1:0] pre_cnt;
  logic [EVT_W-1:0] evt_cnt;
  logic             done_q, ovf_q;
  logic [RD_W-1:0]  rd_q;

  assign start   = wr_en_i & wr_data_i[CTL_START];
  assign ovf_clr = wr_en_i & wr_data_i[CTL_OVF_CLR];

  always_ff @(posedge clk_i) begin
    if (rst_i)      alt_q <= 1'b0;
    else if (start) alt_q <= wr_data_i[CTL_ALT];
  end

  gfc_timebase #(.TB_DIV(TB_DIV)) tb_i (
    .clk_i(clk_i), .rst_i(rst_i), .restart_i(start), .run_i(gate),
    .alt_sel_i(alt_q), .alt_tick_i(alt_tick_i), .tick_o(tick)
  );

  gfc_gate #(.BASE_TICKS(BASE_TICKS)) gate_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start),
    .code_i(wr_data_i[CTL_RES_LSB +: 3]), .tick_i(tick),
    .gate_o(gate), .fin_o(fin)
  );

  gfc_edge_count #(.PRE_W(PRE_W), .EVT_W(EVT_W)) cnt_i (
    .clk_i(clk_i), .rst_i(rst_i), .clear_i(start), .gate_i(gate),
    .sig_i(sig_i), .pre_o(pre_cnt), .evt_o(evt_cnt), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (!irq_ack_i) done_q <= 1'b0;
      else if (fin)   done_q <= 1'b1;
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (rd_pre_i)      rd_q <= RD_W'(pre_cnt);
      else if (rd_evt_i) rd_q <= RD_W'(evt_cnt);
    end
  end

  assign rd_data_o  = rd_q;
  assign gate_o     = gate;
  assign irq_done_o = done_q;
  assign irq_ovf_o  = ovf_q;
endmodule

// File: rtl/gfc_checker.sv
module gfc_checker #(
  parameter int PRE_W = 8,
  parameter int EVT_W = 16,
  parameter int RD_W  = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic [5:0]       wr_data_i,
  input logic             rd_pre_i,
  input logic             irq_ack_i,
  input logic [RD_W-1:0]  rd_data_o,
  input logic             gate_o,
  input logic             irq_done_o,
  input logic             irq_ovf_o,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [EVT_W-1:0] evt_cnt
);
  // R1: reset leaves outputs quiet
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> (!gate_o && !irq_done_o && !irq_ovf_o));

  // R8: low acknowledge drops the completion flag
  a_r8_ack_low_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    !irq_ack_i |=> !irq_done_o);

  // R8: completion only rises when the window closes
  a_r8_done_at_close: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_done_o) |-> $fell(gate_o));

  // R9: overflow flag sticky until a clear write
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_ovf_o && !(wr_en_i && wr_data_i[5])) |=> irq_ovf_o);

  // R6: closed window freezes the counters
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!gate_o && !(wr_en_i && wr_data_i[0])) |=> ($stable(pre_cnt) && $stable(evt_cnt)));

  // R7: prescaler read lands on the next cycle
  a_r7_read_pre: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_pre_i |=> (rd_data_o[PRE_W-1:0] == $past(pre_cnt)));
endmodule

bind gated_freq_counter gfc_checker #(.PRE_W(PRE_W), .EVT_W(EVT_W), .RD_W(RD_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_pre_i(rd_pre_i), .irq_ack_i(irq_ack_i), .rd_data_o(rd_data_o),
  .gate_o(gate_o), .irq_done_o(irq_done_o), .irq_ovf_o(irq_ovf_o),
  .pre_cnt(pre_cnt), .evt_cnt(evt_cnt)
);

// File: tb/gated_freq_counter_tb_top.sv
module gated_freq_counter_tb_top;
  localparam int TB_DIV = 5;
  localparam int BASE   = 40;
  localparam int PRE_W  = 8;
  localparam int EVT_W  = 4;
  localparam int RD_W   = 8;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic sig_i = 1'b0, alt_tick_i = 1'b0, wr_en_i = 1'b0;
  logic [5:0] wr_data_i = '0;
  logic rd_pre_i = 1'b0, rd_evt_i = 1'b0, irq_ack_i = 1'b1;
  logic [RD_W-1:0] rd_data_o;
  logic gate_o, irq_done_o, irq_ovf_o;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  gated_freq_counter #(.TB_DIV(TB_DIV), .BASE_TICKS(BASE), .PRE_W(PRE_W), .EVT_W(EVT_W)) dut_i (
    .clk_i(clk), .rst_i(rst_i), .sig_i(sig_i), .alt_tick_i(alt_tick_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_pre_i(rd_pre_i), .rd_evt_i(rd_evt_i),
    .irq_ack_i(irq_ack_i), .rd_data_o(rd_data_o), .gate_o(gate_o),
    .irq_done_o(irq_done_o), .irq_ovf_o(irq_ovf_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic gate_len(output int n);
    n = 0;
    while (gate_o) begin n++; @(negedge clk); end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sig_i = 1'b1; repeat (2) @(negedge clk);
      sig_i = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic rd(input bit pre, output int v);
    @(negedge clk); rd_pre_i = pre; rd_evt_i = !pre;
    @(negedge clk); rd_pre_i = 1'b0; rd_evt_i = 1'b0; v = int'(rd_data_o);
  endtask

  task automatic measure(input logic [2:0] code, input int n, output int total);
    int p, e, len;
    wr({2'b00, code, 1'b1});
    repeat (2) @(negedge clk);
    pulses(n);
    gate_len(len);
    repeat (2) @(negedge clk);
    rd(1'b1, p); rd(1'b0, e);
    total = e * 256 + p;
  endtask

  task automatic t_reset();
    check(!gate_o && !irq_done_o && !irq_ovf_o, "R1 flags", {gate_o, irq_done_o, irq_ovf_o}, 0);
    check(rd_data_o == 0, "R1 rd_data", int'(rd_data_o), 0);
  endtask

  task automatic t_gate_len(input logic [2:0] code, input int exp);
    int n;
    wr({2'b00, code, 1'b1});
    gate_len(n);
    check(n == exp, $sformatf("R3 gate code %0d", code), n, exp);
    check(irq_done_o, "R8 done at close", irq_done_o, 1);
  endtask

  task automatic t_alt();
    int n;
    alt_tick_i = 1'b1;
    wr(6'b010101);
    gate_len(n);
    check(n == BASE, "R4 alt tick window", n, BASE);
    alt_tick_i = 1'b0;
  endtask

  task automatic t_count();
    int t, p;
    measure(3'd2, 20, t);
    check(t == 20, "R5 short burst", t, 20);
    pulses(10);
    rd(1'b1, p);
    check(p == 20, "R6 edges outside gate", p, 20);
    measure(3'd2, 0, t);
    check(t == 0, "R2 start clears counts", t, 0);
    measure(3'd1, 300, t);
    check(t == 300, "R5 prescaler carry", t, 300);
  endtask

  task automatic t_read_both();
    @(negedge clk); rd_pre_i = 1'b1; rd_evt_i = 1'b1;
    @(negedge clk); rd_pre_i = 1'b0; rd_evt_i = 1'b0;
    check(rd_data_o == 8'd44, "R7 both strobes pick prescaler", int'(rd_data_o), 44);
    repeat (3) @(negedge clk);
    check(rd_data_o == 8'd44, "R7 hold without strobe", int'(rd_data_o), 44);
  endtask

  task automatic t_done_ack();
    int n;
    irq_ack_i = 1'b0;
    wr(6'b000101);
    gate_len(n);
    @(negedge clk);
    check(!irq_done_o, "R8 no done while ack low", irq_done_o, 0);
    irq_ack_i = 1'b1;
    repeat (2) @(negedge clk);
    check(!irq_done_o, "R8 stays clear after ack high", irq_done_o, 0);
    wr(6'b000101);
    gate_len(n);
    check(irq_done_o, "R8 done with ack high", irq_done_o, 1);
    irq_ack_i = 1'b0;
    @(negedge clk);
    check(!irq_done_o, "R8 ack low clears", irq_done_o, 0);
    irq_ack_i = 1'b1;
  endtask

  task automatic t_ovf();
    int t, n;
    measure(3'd0, 4100, t);
    check(irq_ovf_o, "R9 overflow set", irq_ovf_o, 1);
    check(t == 4, "R5 count wraps", t, 4);
    wr(6'b000101);
    gate_len(n);
    check(irq_ovf_o, "R9 sticky over new gate", irq_ovf_o, 1);
    wr(6'b100000);
    check(!irq_ovf_o, "R9 clear write", irq_ovf_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_i = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate_len(3'd2, BASE * TB_DIV);
    t_gate_len(3'd7, BASE * TB_DIV);
    t_gate_len(3'd1, BASE * 10 * TB_DIV);
    t_gate_len(3'd0, BASE * 100 * TB_DIV);
    t_alt();
    t_count();
    t_read_both();
    t_done_ack();
    t_ovf();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule